// File: doc/BRIEF.md
# UART Wrap-Around Self-Test Sequencer

This block checks a small UART transmitter and receiver against each other. A start request makes it capture a test byte into the transmit holding register. In the following cycle it issues a separate control write, and only that write launches the serial transfer and arms the receiver. The frame has eight data bits sent least significant bit first, with one start bit and one stop bit. When the wrap-around select is high, the serial output feeds the receiver directly, so the whole transmit and receive path is checked with no external terminal attached.

The receiver oversamples the line with a tick sixteen times per bit and samples each bit at its middle. When it reports a finished character, the sequencer compares the received byte with the held byte. On a match it raises a pass level and pulses an advance request so that the next self-test can begin. A wrong byte, a low stop bit, or no character within twelve bit times each stops the sequencer in a halted state with its own fault code. Only a reset clears that halted state. With the wrap-around select low, the receiver listens to an external serial input instead.

Top module: `uart_wrap_selftest`

## Requirements
- R1: During and after reset, pass, advance and halted are 0, fault_code is 0, and tx_ser is 1 (idle line).
- R2: Loading the byte does not start the line. tx_ser stays 1 after the edge that follows the start edge and first goes low one edge later, when the control write is issued.
- R3: The transmitted frame is a 0 start bit, then test_byte bit 0 through bit 7, then a 1 stop bit. Each bit lasts exactly 16*BAUD_DIV clocks, measured from the control-write edge.
- R4: With wrap_en high, a complete transfer ends with pass at 1, halted at 0 and fault_code at 0. advance is high for exactly the one cycle in which pass rises.
- R5: Every run resolves (pass or halted) within 12*16*BAUD_DIV+3 clock edges of the start edge.
- R6: A received byte that differs from the held byte, with a good stop bit, gives halted=1 and fault_code=1.
- R7: If no character arrives, halted=1 and fault_code=2 appear on the edge 12*16*BAUD_DIV+2 edges after the start edge.
- R8: A stop bit sampled low gives halted=1 and fault_code=3, even when the data byte matches.
- R9: Once halted, start requests have no effect. halted and fault_code hold until reset.
- R10: A start request while pass is high clears pass and runs a new test.
- R11: The receiver ignores line activity before the control write. A low period that ends before the control write does not produce a character.
- R12: A low pulse shorter than half a bit is rejected as a false start bit, and the receiver goes back to searching for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run one self-test |
| test_byte | input | 8 | Byte to be sent, captured in the load step |
| wrap_en | input | 1 | 1: receiver fed from tx_ser; 0: from rx_ext |
| rx_ext | input | 1 | External serial input (idle high) |
| tx_ser | output | 1 | Serial output of the transmitter |
| pass | output | 1 | Last test passed (level) |
| advance | output | 1 | One-cycle request to move to the next test |
| halted | output | 1 | Sequencer stopped on a fault |
| fault_code | output | 4 | 0 none, 1 mismatch, 2 timeout, 3 framing |

## Verification
The bench goes after the ordering of load and launch. A design that started the line on the data load would drop tx_ser one cycle early. It also goes after the exact bit width of each serial bit: an off-by-one in the oversample count shifts the samples taken at mid-bit. An external frame with a matching byte and a low stop bit checks fault precedence, where a design that compared data first would report a mismatch. The timeout edge is measured to the cycle. Two more cases probe the receiver's start-bit handling. A long low period that ends just before the control write catches a receiver that runs while unarmed, and such a receiver would deliver a wrong byte. A short low glitch after arming catches a receiver that takes any falling edge as a start bit, and that receiver would halt with a fault on a good frame.

// File: rtl/sltst_pkg.sv
package sltst_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ARM, S_WAIT, S_PASS, S_HALT
  } seq_st_t;

  typedef enum logic [1:0] {
    R_HUNT, R_START, R_DATA, R_STOP
  } rx_st_t;

  localparam logic [3:0] FC_NONE     = 4'd0;
  localparam logic [3:0] FC_MISMATCH = 4'd1;
  localparam logic [3:0] FC_TIMEOUT  = 4'd2;
  localparam logic [3:0] FC_FRAMING  = 4'd3;

  // Serial frame, bit 0 leaves first: start(0), data LSB..MSB, stop(1)
  function automatic logic [9:0] make_frame(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  // Verdict on a received character; framing takes precedence
  function automatic logic [3:0] judge(input logic ferr,
                                       input logic [7:0] got,
                                       input logic [7:0] want);
    if (ferr)             return FC_FRAMING;
    else if (got != want) return FC_MISMATCH;
    else                  return FC_NONE;
  endfunction

endpackage

// File: rtl/sltst_tick.sv
module sltst_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));
  assign tick = wrap && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || wrap) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sltst_tx.sv
module sltst_tx
  import sltst_pkg::*;
#(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] data,
  output logic       ser,
  output logic       busy
);
  localparam int OW = $clog2(OVS);

  logic          tick;
  logic [9:0]    frame_q;
  logic [3:0]    left_q;
  logic [OW-1:0] tcnt_q;
  logic          busy_q;

  sltst_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .clr(go), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      tcnt_q  <= '0;
      busy_q  <= 1'b0;
    end else if (go) begin
      frame_q <= make_frame(data);
      left_q  <= 4'd10;
      tcnt_q  <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && tick) begin
      if (tcnt_q == OW'(OVS - 1)) begin
        tcnt_q  <= '0;
        frame_q <= {1'b1, frame_q[9:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign ser  = busy_q ? frame_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/sltst_rx.sv
module sltst_rx
  import sltst_pkg::*;
#(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       ferr
);
  localparam int OW = $clog2(OVS);

  rx_st_t        st_q;
  logic          rs_q, armed_q, done_q, ferr_q, tick, detect;
  logic [OW-1:0] tcnt_q;
  logic [2:0]    nb_q;
  logic [7:0]    sh_q;

  assign detect = (st_q == R_HUNT) && armed_q && !rs_q;

  sltst_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .clr(detect), .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= R_HUNT; rs_q <= 1'b1; armed_q <= 1'b0; done_q <= 1'b0;
      ferr_q <= 1'b0; tcnt_q <= '0; nb_q <= '0; sh_q <= '0;
    end else begin
      rs_q   <= rxd;
      done_q <= 1'b0;
      if (arm) armed_q <= 1'b1;
      case (st_q)
        R_HUNT: if (detect) begin st_q <= R_START; tcnt_q <= '0; end
        R_START: if (tick) begin
          if (tcnt_q == OW'(OVS / 2 - 1)) begin
            tcnt_q <= '0; nb_q <= '0;
            st_q   <= rs_q ? R_HUNT : R_DATA;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        R_DATA: if (tick) begin
          if (tcnt_q == OW'(OVS - 1)) begin
            tcnt_q <= '0;
            sh_q   <= {rs_q, sh_q[7:1]};
            nb_q   <= nb_q + 1'b1;
            if (nb_q == 3'd7) st_q <= R_STOP;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        R_STOP: if (tick) begin
          if (tcnt_q == OW'(OVS - 1)) begin
            done_q  <= 1'b1;
            ferr_q  <= !rs_q;
            armed_q <= 1'b0;
            st_q    <= R_HUNT;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= R_HUNT;
      endcase
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/uart_wrap_selftest.sv
module uart_wrap_selftest
  import sltst_pkg::*;
#(
  parameter int BAUD_DIV = 4,
  parameter int OVS      = 16,
  parameter int TMO_BITS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] test_byte,
  input  logic       wrap_en,
  input  logic       rx_ext,
  output logic       tx_ser,
  output logic       pass,
  output logic       advance,
  output logic       halted,
  output logic [3:0] fault_code
);
  localparam int TMO_CLKS = TMO_BITS * OVS * BAUD_DIV;
  localparam int TW       = $clog2(TMO_CLKS + 1);

  seq_st_t       st_q;
  logic [7:0]    hold_q;
  logic [TW-1:0] tmr_q;
  logic [3:0]    fault_q;
  logic          adv_q;

  // named internal events (also used by the checker)
  logic       ctrl_wr, in_wait, tx_busy, rx_done, rx_ferr, rx_line;
  logic [7:0] rx_byte;
  logic [3:0] verdict;

  assign ctrl_wr = (st_q == S_ARM);
  assign in_wait = (st_q == S_WAIT);
  assign rx_line = wrap_en ? tx_ser : rx_ext;
  assign verdict = judge(rx_ferr, rx_byte, hold_q);

  sltst_tx #(.DIV(BAUD_DIV), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(ctrl_wr), .data(hold_q),
    .ser(tx_ser), .busy(tx_busy));

  sltst_rx #(.DIV(BAUD_DIV), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(ctrl_wr), .rxd(rx_line),
    .done(rx_done), .data(rx_byte), .ferr(rx_ferr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; hold_q <= '0; tmr_q <= '0; fault_q <= FC_NONE; adv_q <= 1'b0;
    end else begin
      adv_q <= 1'b0;
      case (st_q)
        S_IDLE, S_PASS: if (start) st_q <= S_LOAD;
        S_LOAD: begin hold_q <= test_byte; st_q <= S_ARM; end
        S_ARM:  begin tmr_q <= '0; st_q <= S_WAIT; end
        S_WAIT: begin
          if (rx_done) begin
            if (verdict == FC_NONE) begin st_q <= S_PASS; adv_q <= 1'b1; end
            else begin st_q <= S_HALT; fault_q <= verdict; end
          end else if (tmr_q == TW'(TMO_CLKS - 1)) begin
            st_q <= S_HALT; fault_q <= FC_TIMEOUT;
          end else tmr_q <= tmr_q + 1'b1;
        end
        S_HALT: st_q <= S_HALT;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign pass       = (st_q == S_PASS);
  assign advance    = adv_q;
  assign halted     = (st_q == S_HALT);
  assign fault_code = fault_q;
endmodule

// File: rtl/sltst_chk.sv
module sltst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pass,
  input logic       advance,
  input logic       halted,
  input logic [3:0] fault_code,
  input logic       tx_ser,
  input logic       tx_busy,
  input logic       ctrl_wr,
  input logic       in_wait,
  input logic       rx_done
);
  // R2
  line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> tx_ser);
  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr |=> (tx_busy && !tx_ser));
  // R4
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) advance |=> !advance);
  // R4
  adv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) advance |-> (pass && !halted));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |=> (halted && $stable(fault_code)));
  // R6
  fault_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |-> (fault_code inside {4'd1, 4'd2, 4'd3}));
  // R4
  no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n) !halted |-> (fault_code == 4'd0));
  // R11
  rx_armed_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> in_wait);
endmodule

bind uart_wrap_selftest sltst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pass(pass), .advance(advance), .halted(halted),
  .fault_code(fault_code), .tx_ser(tx_ser), .tx_busy(tx_busy),
  .ctrl_wr(ctrl_wr), .in_wait(in_wait), .rx_done(rx_done));

// File: tb/uart_wrap_selftest_tb.sv
`timescale 1ns/1ps
module uart_wrap_selftest_tb;
  localparam int BIT = 64;        // 16 ticks * divisor 4
  localparam int TMO = 12 * BIT;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wrap_en = 1'b1, rx_ext = 1'b1;
  logic [7:0] test_byte = 8'h00;
  logic tx_ser, pass, advance, halted;
  logic [3:0] fault_code;

  int compared = 0, mismatched = 0, cyc = 0;
  bit mon_en = 0, pend = 0, m_pass = 0, m_halt = 0;
  logic [3:0] m_fault = 0, exp_fc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  uart_wrap_selftest u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_byte(test_byte),
    .wrap_en(wrap_en), .rx_ext(rx_ext), .tx_ser(tx_ser), .pass(pass),
    .advance(advance), .halted(halted), .fault_code(fault_code));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] pack(input bit a, input bit p, input bit h, input logic [3:0] f);
    return {a, p, h, f};
  endfunction

  // reference model compared on every clock
  always @(negedge clk) if (mon_en) begin
    logic [6:0] act, exp;
    act = pack(advance, pass, halted, fault_code);
    if (pend && (pass || halted)) begin
      exp = pack(exp_fc == 0, exp_fc == 0, exp_fc != 0, exp_fc);
      chk(act == exp, cur_req, {9'd0, act}, {9'd0, exp});
      m_pass = (exp_fc == 0); m_halt = (exp_fc != 0); m_fault = exp_fc; pend = 0;
    end else if (pend) begin
      exp = pack(0, 0, 0, 4'd0);
      chk(act == exp, cur_req, {9'd0, act}, {9'd0, exp});
    end else begin
      exp = pack(0, m_pass, m_halt, m_fault);
      chk(act == exp, cur_req, {9'd0, act}, {9'd0, exp});
    end
  end

  task automatic drv_pt();
    @(negedge clk); #1;
  endtask

  task automatic do_start(input logic [7:0] b, input logic [3:0] fc);
    drv_pt();
    test_byte = b; exp_fc = fc; start = 1'b1;
    @(posedge clk);
    if (!m_halt) begin pend = 1; m_pass = 0; end
    #1 start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (pend && n < TMO + 3) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(!pend, req, 16'(n), 16'(TMO + 3));
  endtask

  task automatic send_ext(input logic [7:0] b, input bit stopb);
    logic [9:0] fr;
    fr = {stopb, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      drv_pt(); rx_ext = fr[i];
      repeat (BIT - 1) @(negedge clk);
    end
    drv_pt(); rx_ext = 1'b1;
  endtask

  task automatic do_reset();
    drv_pt(); rst_n = 1'b0; pend = 0; m_pass = 0; m_halt = 0; m_fault = 0;
    repeat (3) @(negedge clk);
    #0.5;
    chk(tx_ser == 1'b1, "R1", {15'd0, tx_ser}, 16'd1);
    #0.5 rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pass, advance, halted, fault_code} == 7'd0, "R1", {9'd0, pass, advance, halted, fault_code}, 16'd0);
    chk(tx_ser == 1'b1, "R1", {15'd0, tx_ser}, 16'd1);
    drv_pt(); rst_n = 1'b1; mon_en = 1;
    repeat (5) @(negedge clk);

    // R2 R3 R4: wrap-around pass, with the frame checked on the line
    cur_req = "R4";
    begin
      logic [9:0] fr;
      fr = {1'b1, 8'hA5, 1'b0};
      do_start(8'hA5, 4'd0);
      for (int k = 1; k <= 35 + 9 * BIT; k++) begin
        @(negedge clk);
        if (k == 2) chk(tx_ser == 1'b1, "R2", {15'd0, tx_ser}, 16'd1);
        if (k == 3) chk(tx_ser == 1'b0, "R2", {15'd0, tx_ser}, 16'd0);
        if (k >= 35 && (k - 35) % BIT == 0)
          chk(tx_ser == fr[(k - 35) / BIT], "R3", {15'd0, tx_ser}, {15'd0, fr[(k - 35) / BIT]});
      end
      wait_done("R5");
      chk(pass == 1'b1, "R4", {15'd0, pass}, 16'd1);
    end

    // R10: back-to-back runs from the pass state
    cur_req = "R10";
    do_start(8'h5A, 4'd0); wait_done("R10");
    do_start(8'h00, 4'd0); wait_done("R10");
    do_start(8'hFF, 4'd0); wait_done("R10");
    chk(pass == 1'b1, "R10", {15'd0, pass}, 16'd1);

    // R12: short false start, then a good frame from outside
    cur_req = "R12";
    wrap_en = 1'b0;
    do_start(8'h3C, 4'd0);
    repeat (5) @(negedge clk);
    drv_pt(); rx_ext = 1'b0; repeat (8) @(negedge clk);
    drv_pt(); rx_ext = 1'b1; repeat (20) @(negedge clk);
    send_ext(8'h3C, 1'b1);
    wait_done("R12");
    chk(pass == 1'b1, "R12", {15'd0, pass}, 16'd1);

    // R11: low period ending before the control write is ignored
    cur_req = "R11";
    drv_pt(); rx_ext = 1'b0; repeat (480) @(negedge clk);
    drv_pt(); rx_ext = 1'b1; repeat (10) @(negedge clk);
    do_start(8'h96, 4'd0);
    repeat (20) @(negedge clk);
    send_ext(8'h96, 1'b1);
    wait_done("R11");
    chk(pass == 1'b1 && halted == 1'b0, "R11", {14'd0, pass, halted}, 16'd2);

    // R6: mismatch, then R9: start ignored while halted
    cur_req = "R6";
    do_start(8'h3C, 4'd1);
    repeat (5) @(negedge clk);
    send_ext(8'h3D, 1'b1);
    wait_done("R6");
    chk(halted && fault_code == 4'd1, "R6", {11'd0, halted, fault_code}, 16'h11);
    cur_req = "R9";
    do_start(8'h3C, 4'd0);
    repeat (BIT * 11) @(negedge clk);
    chk(halted && fault_code == 4'd1, "R9", {11'd0, halted, fault_code}, 16'h11);
    do_reset();

    // R8: matching byte with a low stop bit
    cur_req = "R8";
    do_start(8'hC3, 4'd3);
    repeat (5) @(negedge clk);
    send_ext(8'hC3, 1'b0);
    wait_done("R8");
    chk(halted && fault_code == 4'd3, "R8", {11'd0, halted, fault_code}, 16'h13);
    do_reset();

    // R7: silent line, exact timeout edge
    cur_req = "R7";
    begin
      int k = 0;
      do_start(8'h81, 4'd2);
      while (!halted && k < TMO + 10) begin @(negedge clk); k++; end
      chk(k == TMO + 3, "R7", 16'(k), 16'(TMO + 3));
      chk(fault_code == 4'd2, "R7", {12'd0, fault_code}, 16'd2);
    end
    do_reset();
    repeat (4) @(negedge clk);
    chk({pass, advance, halted, fault_code} == 7'd0, "R1", {9'd0, pass, advance, halted, fault_code}, 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule